// File: doc/BRIEF.md
# Multiprocessor Interrupt Steering Controller

This block gathers device interrupt lines into one global pending word and filters them through a global mask. It sends every unmasked device request to a single CPU, chosen by a target register. Each CPU also owns sixteen software interrupt bits that software raises and drops through write-one aliases. For every CPU the block reports the highest active request as a 4-bit processor interrupt level, where zero means no request.

Software reaches the block through a word-addressed register bus with a combinational read path. CPU `c` owns the three words starting at word address `4*c`. In that order they are its pending word, its clear alias and its set alias. The global group starts at word address `4*NCPU` and holds five words in this order: device pending, mask, mask-clear alias, mask-set alias and target. Every level output is registered.

Top module: `irq_steer`

## Requirements
- R1: After reset the mask reads 0xF07FFF80 (every implemented device bit and the master bit 31 set), the target reads 0, every CPU pending word reads 0, and all levels stay 0 even when every device line is high.
- R2: A write to the mask-set alias sets the mask bits where the written data has ones, limited to the implemented bits 0xF07FFF80. Zero bits leave the mask unchanged.
- R3: A write to the mask-clear alias clears the mask bits where the written data has ones. Zero bits leave the mask unchanged.
- R4: While mask bit 31 is set, no device source raises any CPU level.
- R5: The global pending word reads the live device lines ANDed with 0x707FFF80. Writes to any pending word have no effect.
- R6: An unmasked device bit drives these levels: bit 18 to 4, bit 16 to 6, bit 20 to 8, bit 19 to 10, bits 15 and 14 to 12, bit 17 to 13, bit 30 to 9, bit 22 to 11. Slot bits 7 to 13 drive levels 2, 3, 5, 7, 9, 11 and 13 in that order.
- R7: Device bits 21, 28 and 29 appear in the pending word but raise no level. Every unimplemented bit raises no level.
- R8: Software interrupt x of CPU c is bit 16+x of that CPU's pending word. Ones written to the CPU's set word raise those bits, and ones written to its clear word drop them. A pending bit x gives level x, so bit 0 gives level 0.
- R9: A CPU's level is the highest of its software levels and, only when it is the target, the unmasked device levels.
- R10: Only the CPU whose index is in the target register (bits 1:0 for four CPUs) receives device levels.
- R11: A level output changes at the first rising clock edge after the state that causes it changes. A register write therefore shows at the second edge, and a device line change shows at the first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| dev_irq | input | 32 | Device request lines, active high |
| cpu_level | output | 4*NCPU | Interrupt level per CPU, CPU c at bits 4c+3:4c |

## Verification
A change to the global mask and a change on a device line can land on the same clock edge. The bench provokes this by raising the system-timer line in the same cycle as a mask-clear write that unmasks it. The level must stay at zero for one edge, because the old mask is still in force when that edge samples the line, and must then read 10 one edge later. The bench also lowers the line and checks that the level holds until the next edge and then returns to zero.

// File: rtl/irq_steer.sv
module irq_steer #(
  parameter int NCPU = 4,
  parameter int AW   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       dev_irq,
  output logic [NCPU*4-1:0] cpu_level
);
  localparam int TW = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam int GB = NCPU * 4;
  localparam logic [31:0] DEV_IMPL = 32'h707F_FF80;
  localparam logic [31:0] MSK_IMPL = DEV_IMPL | 32'h8000_0000;
  localparam logic [AW-1:0] A_GPEND = AW'(GB);
  localparam logic [AW-1:0] A_MASK  = AW'(GB + 1);
  localparam logic [AW-1:0] A_MCLR  = AW'(GB + 2);
  localparam logic [AW-1:0] A_MSET  = AW'(GB + 3);
  localparam logic [AW-1:0] A_TGT   = AW'(GB + 4);

  logic [31:0]            mask_q;
  logic [TW-1:0]          tgt_q;
  logic [NCPU-1:0][15:0]  soft_q;
  logic [NCPU-1:0][3:0]   lvl_q, lvl_nxt;
  logic [31:0]            dev_pend, dev_eff;
  logic [3:0]             dev_max;

  function automatic logic [3:0] dev_lvl(input int b);
    case (b)
      7:  return 4'd2;
      8:  return 4'd3;
      9:  return 4'd5;
      10: return 4'd7;
      11: return 4'd9;
      12: return 4'd11;
      13: return 4'd13;
      14, 15: return 4'd12;
      16: return 4'd6;
      17: return 4'd13;
      18: return 4'd4;
      19: return 4'd10;
      20: return 4'd8;
      22: return 4'd11;
      30: return 4'd9;
      default: return 4'd0;
    endcase
  endfunction

  assign dev_pend  = dev_irq & DEV_IMPL;
  assign dev_eff   = dev_pend & ~mask_q & {32{~mask_q[31]}};
  assign cpu_level = lvl_q;

  always_comb begin
    dev_max = '0;
    for (int b = 0; b < 32; b++)
      if (dev_eff[b] && dev_lvl(b) > dev_max) dev_max = dev_lvl(b);
  end

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      logic [3:0] sm;
      sm = '0;
      for (int x = 1; x < 16; x++)
        if (soft_q[c][x]) sm = 4'(x);
      lvl_nxt[c] = (tgt_q == TW'(c) && dev_max > sm) ? dev_max : sm;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NCPU; c++)
      if (bus_addr == AW'(4 * c)) bus_rdata = {soft_q[c], 16'h0};
    case (bus_addr)
      A_GPEND: bus_rdata = dev_pend;
      A_MASK:  bus_rdata = mask_q;
      A_TGT:   bus_rdata = 32'(tgt_q);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= MSK_IMPL;
      tgt_q  <= '0;
      soft_q <= '0;
      lvl_q  <= '0;
    end else begin
      lvl_q <= lvl_nxt;
      if (bus_we) begin
        for (int c = 0; c < NCPU; c++) begin
          if (bus_addr == AW'(4 * c + 1)) soft_q[c] <= soft_q[c] & ~bus_wdata[31:16];
          if (bus_addr == AW'(4 * c + 2)) soft_q[c] <= soft_q[c] | bus_wdata[31:16];
        end
        case (bus_addr)
          A_MCLR:  mask_q <= mask_q & ~(bus_wdata & MSK_IMPL);
          A_MSET:  mask_q <= mask_q | (bus_wdata & MSK_IMPL);
          A_TGT:   tgt_q  <= bus_wdata[TW-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

module irq_steer_chk #(
  parameter int NCPU = 4,
  parameter int AW   = 6,
  parameter int TW   = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_we,
  input logic [AW-1:0]         bus_addr,
  input logic [31:0]           bus_wdata,
  input logic [31:0]           mask_q,
  input logic [TW-1:0]         tgt_q,
  input logic [NCPU-1:0][15:0] soft_q,
  input logic [NCPU*4-1:0]     cpu_level
);
  localparam logic [31:0] MSK_IMPL = 32'hF07F_FF80;
  localparam logic [AW-1:0] A_MCLR = AW'(NCPU * 4 + 2);
  localparam logic [AW-1:0] A_MSET = AW'(NCPU * 4 + 3);

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_MSET) |=>
      ((mask_q & $past(bus_wdata) & MSK_IMPL) == ($past(bus_wdata) & MSK_IMPL)));

  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_MCLR) |=> ((mask_q & $past(bus_wdata)) == 32'h0));

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    // R4
    master_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mask_q[31]) && $past(soft_q[c][15:1]) == 15'h0) |-> cpu_level[4*c +: 4] == 4'h0);

    // R10
    steer_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_level[4*c +: 4] != 4'h0 && $past(soft_q[c][15:1]) == 15'h0) |-> $past(tgt_q) == TW'(c));

    // R8
    soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == AW'(4 * c + 2)) |=>
        ((soft_q[c] & $past(bus_wdata[31:16])) == $past(bus_wdata[31:16])));
  end
endmodule

bind irq_steer irq_steer_chk #(.NCPU(NCPU), .AW(AW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .mask_q(mask_q), .tgt_q(tgt_q),
  .soft_q(soft_q), .cpu_level(cpu_level)
);

// File: tb/irq_steer_tb.sv
`timescale 1ns/1ps
module irq_steer_tb;
  localparam int NCPU = 4;
  localparam int AW   = 6;
  localparam int GB   = NCPU * 4;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, dev_irq = '0;
  logic [31:0] bus_rdata;
  logic [NCPU*4-1:0] cpu_level;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_steer #(.NCPU(NCPU), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_irq(dev_irq),
    .cpu_level(cpu_level)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    bus_addr = AW'(a);
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] lvl(int c);
    return 32'(cpu_level[4*c +: 4]);
  endfunction

  function automatic logic [31:0] exp_dev(int b);
    if (b >= 7 && b <= 13) return (b == 7) ? 32'd2 : 32'(2 * (b - 7) + 1);
    case (b)
      14, 15: return 32'd12;
      16: return 32'd6;
      17: return 32'd13;
      18: return 32'd4;
      19: return 32'd10;
      20: return 32'd8;
      22: return 32'd11;
      30: return 32'd9;
      default: return 32'd0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired (R11) actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(GB + 1, d); check("R1 mask", d, 32'hF07F_FF80);
    rd(GB + 4, d); check("R1 target", d, 32'h0);
    for (int c = 0; c < NCPU; c++) begin
      rd(4 * c, d); check("R1 cpu pending", d, 32'h0);
    end
    dev_irq = 32'hFFFF_FFFF;
    @(negedge clk); @(negedge clk);
    for (int c = 0; c < NCPU; c++) check("R1 level", lvl(c), 32'h0);

    // R5 live pending, writes ignored
    rd(GB, d); check("R5 pend all", d, 32'h707F_FF80);
    dev_irq = 32'hA5A5_A5A5;
    rd(GB, d); check("R5 pend pattern", d, 32'hA5A5_A5A5 & 32'h707F_FF80);
    wr(GB, 32'h0);
    rd(GB, d); check("R5 pend write ignored", d, 32'hA5A5_A5A5 & 32'h707F_FF80);
    wr(0, 32'hFFFF_0000);
    rd(0, d); check("R5 cpu pend write ignored", d, 32'h0);
    dev_irq = 32'h0;

    // R2 R3 mask aliases
    wr(GB + 2, 32'hFFFF_FFFF);
    rd(GB + 1, d); check("R3 clear all", d, 32'h0);
    wr(GB + 3, 32'h00F0_0000);
    rd(GB + 1, d); check("R2 set partial", d, 32'h0070_0000);
    wr(GB + 3, 32'h0);
    rd(GB + 1, d); check("R2 zero write", d, 32'h0070_0000);
    wr(GB + 2, 32'h0040_0000);
    rd(GB + 1, d); check("R3 clear one", d, 32'h0030_0000);
    wr(GB + 2, 32'h0);
    rd(GB + 1, d); check("R3 zero write", d, 32'h0030_0000);
    wr(GB + 2, 32'hFFFF_FFFF);

    // R6 R7 R10 sweep of target and every device bit
    for (int t = 0; t < NCPU; t++) begin
      wr(GB + 4, 32'(t));
      rd(GB + 4, d); check("R10 target read", d, 32'(t));
      for (int b = 0; b < 32; b++) begin
        dev_irq = 32'h1 << b;
        @(negedge clk);
        for (int c = 0; c < NCPU; c++) begin
          if (c != t) check("R10 non-target", lvl(c), 32'h0);
          else if (b == 21 || b == 28 || b == 29 || exp_dev(b) == 0)
            check("R7 no level", lvl(c), exp_dev(b));
          else check("R6 device level", lvl(c), exp_dev(b));
        end
      end
    end

    // R4 master bit
    dev_irq = 32'h707F_FF80;
    @(negedge clk);
    check("R6 all devices", lvl(3), 32'd13);
    wr(GB + 3, 32'h8000_0000);
    @(negedge clk);
    for (int c = 0; c < NCPU; c++) check("R4 master blocks", lvl(c), 32'h0);
    rd(GB + 1, d); check("R2 master set", d, 32'h8000_0000);
    wr(GB + 2, 32'h8000_0000);
    @(negedge clk);
    check("R4 master released", lvl(3), 32'd13);

    // R11 mask write and device change in the same cycle
    dev_irq = 32'h0;
    wr(GB + 4, 32'h0);
    wr(GB + 3, 32'h0008_0000);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(GB + 2); bus_wdata = 32'h0008_0000;
    dev_irq = 32'h0008_0000;
    #1 check("R11 before edge", lvl(0), 32'h0);
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    check("R11 old mask sampled", lvl(0), 32'h0);
    @(negedge clk);
    check("R11 new mask", lvl(0), 32'd10);
    dev_irq = 32'h0;
    #1 check("R11 hold until edge", lvl(0), 32'd10);
    @(negedge clk);
    check("R11 drop after edge", lvl(0), 32'h0);

    // R8 software interrupts, every CPU and bit
    for (int c = 0; c < NCPU; c++) begin
      for (int x = 0; x < 16; x++) begin
        wr(4 * c + 2, 32'h1 << (16 + x));
        @(negedge clk);
        for (int k = 0; k < NCPU; k++)
          check("R8 soft level", lvl(k), (k == c) ? 32'(x) : 32'h0);
        rd(4 * c, d); check("R8 soft pending", d, 32'h1 << (16 + x));
        wr(4 * c + 1, 32'h1 << (16 + x));
        rd(4 * c, d); check("R8 soft cleared", d, 32'h0);
      end
    end
    wr(6, 32'h0208_0000);
    wr(6, 32'h0);
    rd(4, d); check("R8 zero set write", d, 32'h0208_0000);
    @(negedge clk);
    check("R8 highest soft", lvl(1), 32'd9);
    wr(5, 32'h0200_0000);
    @(negedge clk);
    check("R8 after partial clear", lvl(1), 32'd3);
    wr(5, 32'hFFFF_0000);

    // R9 soft and device combined
    wr(GB + 4, 32'd2);
    dev_irq = 32'h0004_0000;
    wr(10, 32'h0008_0000);
    @(negedge clk);
    check("R9 device above soft", lvl(2), 32'd4);
    wr(10, 32'h0080_0000);
    @(negedge clk);
    check("R9 soft above device", lvl(2), 32'd7);
    wr(14, 32'h0020_0000);
    @(negedge clk);
    check("R9 non-target soft only", lvl(3), 32'd5);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule